// File: doc/BRIEF.md
# Conditional Trap Compare Unit

This block decides whether a conditional trap instruction fires. It takes two operands and a five-bit condition mask. Each mask bit enables one relation between the operands: signed less-than, signed greater-than, equality, unsigned less-than or unsigned greater-than. The trap fires when at least one enabled relation holds. The compare runs at one of two widths, picked by a mode input:

- **Word mode** looks only at the low 32 bits of each operand, with the sign taken from bit 31.
- **Doubleword mode** compares all 64 bits.

An upstream issue stage presents one compare per cycle with a valid strobe. One cycle later the unit returns a registered trap flag and a cause code for the program exception that the trap raises. The exception entry logic downstream consumes both. This block does not decode instructions or sequence exception entry.

Top module: `trap_cmp_unit`

## Requirements
- R1: Mask bit 4 (value 0x10) enables the signed less-than relation (A < B as two's complement).
- R2: Mask bit 3 (value 0x08) enables the signed greater-than relation (A > B as two's complement).
- R3: Mask bit 2 (value 0x04) enables the equality relation (A == B).
- R4: Mask bit 1 (value 0x02) enables unsigned less-than, and mask bit 0 (value 0x01) enables unsigned greater-than.
- R5: The trap fires exactly when at least one enabled relation is true. It does not fire when only disabled relations hold.
- R6: With `mode_dw_i` = 0 (word mode), only bits 31:0 of each operand take part, and the signed relations use bit 31 as the sign. Bits 63:32 have no effect on the result.
- R7: With `mode_dw_i` = 1 (doubleword mode), all 64 bits take part, and the signed relations use bit 63 as the sign.
- R8: A mask of 5'b00000 never traps, and a mask of 5'b11111 always traps, whatever the operands are.
- R9: `trap_o` shows the decision for a strobe in the cycle after `valid_i` was high. It is low in any cycle that follows a cycle without a strobe.
- R10: `cause_o` reads 4'h2 (trap cause) in every cycle where `trap_o` is high, and 4'h0 otherwise. After reset, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Compare strobe; operands, mask and mode are taken in this cycle |
| mode_dw_i | input | 1 | Compare width: 0 = low 32 bits, 1 = full 64 bits |
| mask_i | input | 5 | Condition mask: [4] signed lt, [3] signed gt, [2] eq, [1] unsigned lt, [0] unsigned gt |
| opa_i | input | 64 | Left operand A |
| opb_i | input | 64 | Right operand B |
| trap_o | output | 1 | Registered trap decision |
| cause_o | output | 4 | Registered program-exception cause (4'h2 on trap, else 0) |

## Verification
One pair of operands, all ones against one, is replayed under single-bit masks. It is negative as a signed number and huge as an unsigned one, so it shows whether the signed and unsigned relations are wired to the right mask bits. Other operand pairs differ only in their upper halves, or flip sign between bit 31 and bit 63, and each is run in both modes. These pairs show whether word mode truly ignores the upper bits and takes its sign from bit 31. A further run compares equal operands under a mask that enables every relation except equality, and it must not trap. Last, a pseudo-random sweep with frequent equal or low-half-equal operands is checked against an independent model. Strobe gaps and back-to-back strobes cover the one-cycle timing.

// File: rtl/trap_cmp_pkg.sv
package trap_cmp_pkg;

  // Number of selectable relations; one mask bit each.
  localparam int REL_N = 5;

  // Cause code width and values handed to exception entry.
  localparam int CAUSE_W = 4;
  localparam logic [CAUSE_W-1:0] CAUSE_NONE = 4'h0;
  localparam logic [CAUSE_W-1:0] CAUSE_TRAP = 4'h2;

  typedef enum logic {
    CMP_WORD  = 1'b0,
    CMP_DWORD = 1'b1
  } cmp_mode_e;

  // Packed MSB-first so that bit positions match the mask bits.
  typedef struct packed {
    logic slt;  // [4]
    logic sgt;  // [3]
    logic eq;   // [2]
    logic ult;  // [1]
    logic ugt;  // [0]
  } rel_flags_t;

endpackage

// File: rtl/trap_operand_prep.sv
module trap_operand_prep
  import trap_cmp_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int WORD_W = 32
) (
  input  cmp_mode_e         mode,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic [DATA_W-1:0] opa_sx,
  output logic [DATA_W-1:0] opb_sx,
  output logic [DATA_W-1:0] opa_zx,
  output logic [DATA_W-1:0] opb_zx
);

  localparam int PAD_W = DATA_W - WORD_W;

  generate
    if (PAD_W > 0) begin : g_narrow
      // Word mode widens the low part so one full-width comparator serves both modes.
      function automatic logic [DATA_W-1:0] widen_signed(input logic [DATA_W-1:0] v);
        return {{PAD_W{v[WORD_W-1]}}, v[WORD_W-1:0]};
      endfunction

      function automatic logic [DATA_W-1:0] widen_unsigned(input logic [DATA_W-1:0] v);
        return {{PAD_W{1'b0}}, v[WORD_W-1:0]};
      endfunction

      always_comb begin
        if (mode == CMP_DWORD) begin
          opa_sx = opa;
          opb_sx = opb;
          opa_zx = opa;
          opb_zx = opb;
        end else begin
          opa_sx = widen_signed(opa);
          opb_sx = widen_signed(opb);
          opa_zx = widen_unsigned(opa);
          opb_zx = widen_unsigned(opb);
        end
      end
    end else begin : g_full
      // Both widths agree: the mode has nothing to select.
      assign opa_sx = opa;
      assign opb_sx = opb;
      assign opa_zx = opa;
      assign opb_zx = opb;
    end
  endgenerate

endmodule

// File: rtl/trap_rel_eval.sv
module trap_rel_eval
  import trap_cmp_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] opa_sx,
  input  logic [DATA_W-1:0] opb_sx,
  input  logic [DATA_W-1:0] opa_zx,
  input  logic [DATA_W-1:0] opb_zx,
  output rel_flags_t        rel
);

  localparam logic [DATA_W-1:0] SIGN_BIAS = {1'b1, {(DATA_W-1){1'b0}}};

  // Signed order via the offset-binary trick: flipping the sign bit
  // turns two's complement order into unsigned order.
  function automatic logic signed_below(input logic [DATA_W-1:0] x,
                                        input logic [DATA_W-1:0] y);
    return (x ^ SIGN_BIAS) < (y ^ SIGN_BIAS);
  endfunction

  function automatic logic unsigned_below(input logic [DATA_W-1:0] x,
                                          input logic [DATA_W-1:0] y);
    return x < y;
  endfunction

  always_comb begin
    rel.slt = signed_below(opa_sx, opb_sx);
    rel.sgt = signed_below(opb_sx, opa_sx);
    rel.eq  = (opa_zx == opb_zx);
    rel.ult = unsigned_below(opa_zx, opb_zx);
    rel.ugt = unsigned_below(opb_zx, opa_zx);
  end

endmodule

// File: rtl/trap_mask_reduce.sv
module trap_mask_reduce #(
  parameter int REL_W = 5
) (
  input  logic [REL_W-1:0] rel,
  input  logic [REL_W-1:0] mask,
  output logic             hit
);

  logic [REL_W-1:0] sel;

  generate
    for (genvar i = 0; i < REL_W; i++) begin : g_gate
      assign sel[i] = rel[i] & mask[i];
    end
  endgenerate

  assign hit = |sel;

endmodule

// File: rtl/trap_cmp_unit.sv
module trap_cmp_unit
  import trap_cmp_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int WORD_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               valid_i,
  input  logic               mode_dw_i,
  input  logic [REL_N-1:0]   mask_i,
  input  logic [DATA_W-1:0]  opa_i,
  input  logic [DATA_W-1:0]  opb_i,
  output logic               trap_o,
  output logic [CAUSE_W-1:0] cause_o
);

  cmp_mode_e         mode;
  logic [DATA_W-1:0] opa_sx, opb_sx, opa_zx, opb_zx;
  rel_flags_t        rel;
  logic [REL_N-1:0]  rel_vec;
  logic              hit;
  logic              fire;
  logic              trap_q;
  logic [CAUSE_W-1:0] cause_q;

  assign mode = cmp_mode_e'(mode_dw_i);

  trap_operand_prep #(
    .DATA_W (DATA_W),
    .WORD_W (WORD_W)
  ) u_prep (
    .mode   (mode),
    .opa    (opa_i),
    .opb    (opb_i),
    .opa_sx (opa_sx),
    .opb_sx (opb_sx),
    .opa_zx (opa_zx),
    .opb_zx (opb_zx)
  );

  trap_rel_eval #(
    .DATA_W (DATA_W)
  ) u_rel (
    .opa_sx (opa_sx),
    .opb_sx (opb_sx),
    .opa_zx (opa_zx),
    .opb_zx (opb_zx),
    .rel    (rel)
  );

  assign rel_vec = rel;

  trap_mask_reduce #(
    .REL_W (REL_N)
  ) u_reduce (
    .rel  (rel_vec),
    .mask (mask_i),
    .hit  (hit)
  );

  assign fire = valid_i & hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_q  <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else begin
      trap_q  <= fire;
      cause_q <= fire ? CAUSE_TRAP : CAUSE_NONE;
    end
  end

  assign trap_o  = trap_q;
  assign cause_o = cause_q;

  // R1 R2 R3: exactly one of signed lt / eq / signed gt holds
  signed_trichotomy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rel.slt, rel.eq, rel.sgt}) == 1);

  // R4: exactly one of unsigned lt / eq / unsigned gt holds
  unsigned_trichotomy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rel.ult, rel.eq, rel.ugt}) == 1);

  // R5
  selected_hit_traps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && ((mask_i & rel_vec) != '0)) |=> trap_o);

  // R8
  zero_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && mask_i == '0) |=> !trap_o);

  // R8
  full_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && mask_i == '1) |=> trap_o);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> !trap_o);

  // R10
  cause_on_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> cause_o == CAUSE_TRAP);

  // R10
  cause_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_o |-> cause_o == CAUSE_NONE);

endmodule

// File: tb/trap_cmp_unit_tb.sv
`timescale 1ns/1ps
module trap_cmp_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic        mode_dw_i = 1'b0;
  logic [4:0]  mask_i = '0;
  logic [63:0] opa_i = '0;
  logic [63:0] opb_i = '0;
  logic        trap_o;
  logic [3:0]  cause_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  trap_cmp_unit u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_i   (valid_i),
    .mode_dw_i (mode_dw_i),
    .mask_i    (mask_i),
    .opa_i     (opa_i),
    .opb_i     (opb_i),
    .trap_o    (trap_o),
    .cause_o   (cause_o)
  );

  typedef struct packed {
    logic        dw;
    logic [4:0]  mask;
    logic [63:0] a;
    logic [63:0] b;
    logic        exp;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 5'b10000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b1},
    '{1'b1, 5'b00010, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b0},
    '{1'b1, 5'b00001, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b1},
    '{1'b1, 5'b01000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b0},
    '{1'b1, 5'b00100, 64'h123, 64'h123, 1'b1},
    '{1'b1, 5'b11011, 64'h123, 64'h123, 1'b0},
    '{1'b0, 5'b00100, 64'hAAAA_0000_0000_0005, 64'h5555_0000_0000_0005, 1'b1},
    '{1'b1, 5'b00100, 64'hAAAA_0000_0000_0005, 64'h5555_0000_0000_0005, 1'b0},
    '{1'b0, 5'b10000, 64'h0000_0000_8000_0000, 64'h1, 1'b1},
    '{1'b1, 5'b10000, 64'h0000_0000_8000_0000, 64'h1, 1'b0},
    '{1'b0, 5'b00001, 64'h0000_0000_8000_0000, 64'h1, 1'b1},
    '{1'b0, 5'b01000, 64'hFFFF_FFFF_0000_0002, 64'h1, 1'b1},
    '{1'b1, 5'b01000, 64'hFFFF_FFFF_0000_0002, 64'h1, 1'b0},
    '{1'b1, 5'b00000, 64'h1, 64'h2, 1'b0},
    '{1'b0, 5'b11111, 64'h1, 64'h2, 1'b1},
    '{1'b0, 5'b00010, 64'h0000_0001_0000_0000, 64'h1, 1'b1},
    '{1'b1, 5'b00010, 64'h0000_0001_0000_0000, 64'h1, 1'b0}
  };

  function automatic string tag_of(int i);
    case (i)
      0:  return "R1";
      1:  return "R4";
      2:  return "R4";
      3:  return "R2";
      4:  return "R3";
      5:  return "R5";
      6:  return "R6";
      7:  return "R7";
      8:  return "R6";
      9:  return "R7";
      10: return "R6";
      11: return "R6";
      12: return "R7";
      13: return "R8";
      14: return "R8";
      15: return "R6";
      default: return "R7";
    endcase
  endfunction

  // Independent model built on native signed/unsigned integer types.
  function automatic logic model_trap(logic dw, logic [4:0] m, logic [63:0] a, logic [63:0] b);
    logic lt_s, gt_s, eq_v, lt_u, gt_u;
    if (dw) begin
      longint          sa = longint'(a);
      longint          sb = longint'(b);
      longint unsigned ua = a;
      longint unsigned ub = b;
      lt_s = sa < sb; gt_s = sa > sb; eq_v = ua == ub; lt_u = ua < ub; gt_u = ua > ub;
    end else begin
      int          sa = int'(a[31:0]);
      int          sb = int'(b[31:0]);
      int unsigned ua = a[31:0];
      int unsigned ub = b[31:0];
      lt_s = sa < sb; gt_s = sa > sb; eq_v = ua == ub; lt_u = ua < ub; gt_u = ua > ub;
    end
    return (m[4] && lt_s) || (m[3] && gt_s) || (m[2] && eq_v) || (m[1] && lt_u) || (m[0] && gt_u);
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Present one strobe, then sample the registered result at the next falling edge.
  task automatic apply(logic dw, logic [4:0] m, logic [63:0] a, logic [63:0] b);
    @(negedge clk);
    valid_i = 1'b1; mode_dw_i = dw; mask_i = m; opa_i = a; opb_i = b;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic check_out(string req, logic exp);
    check(req, 64'(trap_o), 64'(exp), "trap");
    check("R10", 64'(cause_o), exp ? 64'h2 : 64'h0, "cause");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [63:0] s;
    // Reset state (R10)
    repeat (3) @(negedge clk);
    check("R10", 64'(trap_o), 64'h0, "reset trap");
    check("R10", 64'(cause_o), 64'h0, "reset cause");
    rst_n = 1'b1;

    // Vector table
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].dw, VECS[i].mask, VECS[i].a, VECS[i].b);
      check_out(tag_of(i), VECS[i].exp);
    end

    // R9: all-ones mask and matching operands but no strobe -> no trap
    @(negedge clk);
    valid_i = 1'b0; mask_i = 5'b11111; opa_i = 64'h7; opb_i = 64'h7;
    @(negedge clk);
    check("R9", 64'(trap_o), 64'h0, "no strobe");

    // R9: back-to-back strobes, then a gap
    @(negedge clk);
    valid_i = 1'b1; mode_dw_i = 1'b1; mask_i = 5'b00100; opa_i = 64'h9; opb_i = 64'h9;
    @(negedge clk);
    check("R9", 64'(trap_o), 64'h1, "first of pair");
    mask_i = 5'b00001;
    @(negedge clk);
    check("R9", 64'(trap_o), 64'h0, "second of pair");
    valid_i = 1'b0; mask_i = 5'b00100;
    @(negedge clk);
    check("R9", 64'(trap_o), 64'h0, "gap after pair");
    check("R10", 64'(cause_o), 64'h0, "gap cause");

    // R5: sweep against the model
    s = 64'h9E37_79B9_7F4A_7C15;
    for (int k = 0; k < 64; k++) begin
      logic [63:0] a, b;
      logic [4:0]  m;
      logic        dw;
      s ^= s << 13; s ^= s >> 7; s ^= s << 17;
      a = s;
      s ^= s << 13; s ^= s >> 7; s ^= s << 17;
      b = s;
      if (k % 4 == 0) b = a;
      else if (k % 4 == 1) b = {b[63:32], a[31:0]};
      m  = 5'(s[40:36]);
      dw = s[50];
      apply(dw, m, a, b);
      check_out("R5", model_trap(dw, m, a, b));
    end

    finish_run();
  end

endmodule